// File: doc/BRIEF.md
# Pipelined Multichannel SPI Result Reader

This block is an SPI host that collects conversion results from up to four channels of an attached converter in one burst. The converter answers each frame with the register that the previous frame selected. A trigger latches a channel mask. The engine then sends one read-select frame for each enabled channel, lowest channel number first, and ends with a no-operation frame. Each received frame is assigned to the channel that the frame before it selected, so N enabled channels take N+1 frames.

Each received frame is 32 bits: an address byte, a 16-bit value and a CRC byte. The engine computes the CRC-8 of the first three bytes and compares it with the fourth. It stores the value in that channel's slot of the result bus and sets the channel's error flag when the CRC does not match. A one-cycle completion pulse ends the burst. Results and error flags then stay unchanged until the next accepted trigger.

Top module: `spi_burst_reader`

## Requirements
- R1: A burst with N enabled channels exchanges exactly N+1 frames of 32 bits. Each frame is framed by one low period of `cs_n`.
- R2: Frame k (k = 1..N) carries the k-th enabled channel c, channels taken in ascending order. Its bits are sent MSB first: byte 0x41, byte 0x00, byte 0x26+c, then the CRC-8 of those three bytes.
- R3: The last frame of a non-empty burst is the no-operation word 32'h00000000, which includes its valid CRC of 0x00.
- R4: The receive word of frame k+1 belongs to the k-th enabled channel. Its bits [23:8] are stored in `results[16*c +: 16]`. The receive word of frame 1 has no effect on `results` or `crc_err`, and slots of channels that are not enabled keep their value.
- R5: A received frame is in error when its bits [7:0] differ from the CRC-8 of bits [31:8] (polynomial 0x07, initial value 0x00, MSB first, no final XOR). An error sets `crc_err[c]` for the owning channel. An accepted trigger clears all of `crc_err`.
- R6: A trigger with an empty mask raises `done` in the cycle after the trigger. No frame is sent and `cs_n` stays high.
- R7: `done` is a one-cycle pulse after the last frame. `busy` is high from the cycle after an accepted trigger until `done`. `results` and `crc_err` do not change while the block is idle and no trigger is present.
- R8: The SPI runs in mode 0: `sclk` is low whenever `cs_n` is high, `mosi` changes on falling edges and `miso` is sampled on rising edges. `cs_n` stays high for at least 2*SCK_HALF clock cycles between frames.
- R9: A trigger that arrives while `busy` is high is ignored and does not change the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Trigger; accepted only when idle |
| chan_en | input | NCH | Channel mask, latched on an accepted trigger |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the target |
| miso | input | 1 | SPI data from the target |
| busy | output | 1 | High while a burst is in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| results | output | 16*NCH | Stored 16-bit value of each channel |
| crc_err | output | NCH | CRC error flag of each channel |

## Verification
In one and the same frame the engine sends the selection for the next channel and stores the receive word for the previous one. A wrong pairing of these two actions is therefore the main risk. The bench sweeps all sixteen channel masks against a target model that answers with the register selected one frame earlier. It corrupts the CRC of chosen channels and always corrupts the CRC of the first frame in a burst. For each mask, the bench checks that every stored value and every error flag lands on its own channel and that the ignored first word leaves no trace. A second pairing, a new trigger that arrives during a running burst, is provoked once. It is judged by the frame count and the stored results of the original mask.

// File: rtl/spi_burst_reader.sv
module spi_burst_reader #(
  parameter int NCH      = 4,
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NCH-1:0]   chan_en,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [16*NCH-1:0] results,
  output logic [NCH-1:0]   crc_err
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DW = $clog2(2*SCK_HALF) + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_XFER, S_GAP} state_t;
  state_t st;

  logic [31:0]    tx_sr, rx_sr;
  logic [4:0]     bitc;
  logic [DW-1:0]  divc;
  logic [NCH-1:0] pend;
  logic [CW-1:0]  cur, own, nxt;
  logic           sel_v, own_v, last;

  function automatic logic [7:0] crc8(input logic [23:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  always_comb begin
    nxt = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (pend[i]) nxt = CW'(i);
  end

  logic        has_sel;
  logic [23:0] sel_word;
  logic [31:0] next_frame;
  logic        rx_bad;

  assign has_sel    = |pend;
  assign sel_word   = {8'h41, 8'h00, 8'h26 + 8'(nxt)};
  assign next_frame = has_sel ? {sel_word, crc8(sel_word)} : 32'h0;
  assign rx_bad     = rx_sr[7:0] != crc8(rx_sr[31:8]);

  assign cs_n = (st != S_XFER);
  assign busy = (st != S_IDLE);
  assign mosi = tx_sr[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tx_sr <= '0; rx_sr <= '0; bitc <= '0; divc <= '0;
      pend <= '0; cur <= '0; own <= '0; sel_v <= 1'b0; own_v <= 1'b0;
      last <= 1'b0; sclk <= 1'b0; done <= 1'b0; results <= '0; crc_err <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          done <= 1'b0;
          if (start) begin
            crc_err <= '0;
            if (chan_en == '0) done <= 1'b1;
            else begin
              pend  <= chan_en;
              sel_v <= 1'b0;
              st    <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          tx_sr <= next_frame;
          last  <= ~has_sel;
          own   <= cur;
          own_v <= sel_v;
          sel_v <= has_sel;
          if (has_sel) begin
            cur  <= nxt;
            pend <= pend & (pend - 1'b1);
          end
          bitc <= '0;
          divc <= '0;
          st   <= S_XFER;
        end
        S_XFER: begin
          if (divc == DW'(SCK_HALF-1)) begin
            divc <= '0;
            sclk <= ~sclk;
            if (!sclk) rx_sr <= {rx_sr[30:0], miso};
            else if (bitc == 5'd31) begin
              st <= S_GAP;
              if (own_v) begin
                results[16*own +: 16] <= rx_sr[23:8];
                crc_err[own]          <= rx_bad;
              end
            end else begin
              bitc  <= bitc + 1'b1;
              tx_sr <= {tx_sr[30:0], 1'b0};
            end
          end else divc <= divc + 1'b1;
        end
        S_GAP: begin
          if (divc == DW'(2*SCK_HALF-1)) begin
            divc <= '0;
            if (last) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else st <= S_LOAD;
          end else divc <= divc + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_reader_chk.sv
module spi_burst_reader_chk #(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              sclk,
  input logic              cs_n,
  input logic              busy,
  input logic              done,
  input logic [16*NCH-1:0] results,
  input logic [NCH-1:0]    crc_err
);
  a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r6_cs_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(results) && $stable(crc_err)));

  a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (crc_err == '0));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_burst_reader spi_burst_reader_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .cs_n(cs_n),
  .busy(busy), .done(done), .results(results), .crc_err(crc_err)
);

// File: tb/test_spi_burst_reader.sv
`timescale 1ns/1ps
module test_spi_burst_reader;
  localparam int NCH = 4;
  localparam int SCK_HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic sclk, cs_n, mosi, miso, busy, done;
  logic [16*NCH-1:0] results;
  logic [NCH-1:0] crc_err;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_burst_reader #(.NCH(NCH), .SCK_HALF(SCK_HALF)) i_spi_burst_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .busy(busy), .done(done), .results(results), .crc_err(crc_err));

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [8:0] r;
    r = 9'h0;
    for (int i = 23; i >= 0; i--) begin
      r = {r[7:0], d[i]};
      if (r[8]) r = r ^ 9'h107;
    end
    for (int i = 0; i < 8; i++) begin
      r = {r[7:0], 1'b0};
      if (r[8]) r = r ^ 9'h107;
    end
    return r[7:0];
  endfunction

  // target model
  logic [15:0] vals [NCH];
  logic [NCH-1:0] bad_mask = '0;
  logic [7:0]  sel = 8'h26;
  logic [31:0] in_sr = '0, out_sr = '0;
  logic [31:0] frames [8];
  int fcnt = 0;
  int gap_run = 0, gap_min = 1000;

  assign miso = out_sr[31];

  always @(negedge cs_n) begin
    logic [15:0] v;
    logic [7:0]  c;
    int idx;
    idx = int'(sel) - 'h26;
    v = (idx >= 0 && idx < NCH) ? vals[idx] : 16'hDEAD;
    c = ref_crc({sel, v});
    if (fcnt == 0) c = c ^ 8'h5A;
    else if (idx >= 0 && idx < NCH && bad_mask[idx]) c = c ^ 8'h01;
    out_sr = {sel, v, c};
  end
  always @(posedge sclk) if (!cs_n) in_sr = {in_sr[30:0], mosi};
  always @(negedge sclk) if (!cs_n) out_sr = {out_sr[30:0], 1'b0};
  always @(posedge cs_n) begin
    if (fcnt < 8) frames[fcnt] = in_sr;
    fcnt = fcnt + 1;
    if (in_sr[31:24] == 8'h41 && in_sr[7:0] == ref_crc(in_sr[31:8])) sel = in_sr[15:8];
  end
  always @(posedge clk) begin
    if (cs_n) gap_run <= gap_run + 1;
    else begin
      if (gap_run > 0 && fcnt > 0 && gap_run < gap_min) gap_min <= gap_run;
      gap_run <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [16*NCH-1:0] exp_res = '0;

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic burst(input logic [NCH-1:0] m, input logic [NCH-1:0] bad,
                       input bit intrude);
    int n, cyc, k;
    n = $countones(m);
    for (int c = 0; c < NCH; c++) vals[c] = 16'(16'h1357 * (c + 1) + 16'h0101 * m + (intrude ? 16'h4000 : 0));
    bad_mask = bad;
    fcnt = 0;
    gap_min = 1000;
    @(negedge clk);
    chan_en = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == '0) begin
      chk(done === 1'b1, "R6", "done after empty trigger", 64'(done), 64'h1);
      @(negedge clk);
      chk(fcnt == 0, "R6", "frames for empty mask", 64'(fcnt), 64'h0);
      chk(cs_n === 1'b1, "R6", "cs_n idle", 64'(cs_n), 64'h1);
      return;
    end
    chk(busy === 1'b1, "R7", "busy after trigger", 64'(busy), 64'h1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      chan_en = ~m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(cyc);
    chk(done === 1'b1, "R7", "done seen", 64'(done), 64'h1);
    chk(fcnt == n + 1, intrude ? "R9" : "R1", "frame count", 64'(fcnt), 64'(n + 1));
    k = 0;
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      logic [23:0] w;
      w = {8'h41, 8'h00, 8'h26 + 8'(c)};
      chk(frames[k] == {w, ref_crc(w)}, "R2", "select frame", 64'(frames[k]), 64'({w, ref_crc(w)}));
      k++;
    end
    chk(frames[n] == 32'h0, "R3", "final nop frame", 64'(frames[n]), 64'h0);
    for (int c = 0; c < NCH; c++) if (m[c]) exp_res[16*c +: 16] = vals[c];
    chk(results == exp_res, "R4", "result slots", results, exp_res);
    chk(crc_err == (m & bad), "R5", "crc error mask", 64'(crc_err), 64'(m & bad));
    chk(gap_min >= 2*SCK_HALF, "R8", "cs_n high gap", 64'(gap_min), 64'(2*SCK_HALF));
    @(negedge clk);
    chk(done === 1'b0, "R7", "done single cycle", 64'(done), 64'h0);
    repeat (10) @(negedge clk);
    chk(results == exp_res && crc_err == (m & bad), "R7", "hold after done", results, exp_res);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) vals[c] = '0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R8", "reset pins", {62'b0, cs_n, sclk}, 64'h2);
    chk(done === 1'b0 && busy === 1'b0, "R7", "reset flags", {62'b0, done, busy}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(results == '0 && crc_err == '0, "R4", "reset outputs", results, 64'h0);
    for (int m = 0; m < 16; m++) burst(4'(m), 4'b0000, 1'b0);
    for (int m = 1; m < 16; m++) burst(4'(m), 4'(m * 5), 1'b0);
    burst(4'b1010, 4'b0010, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule